// File: doc/BRIEF.md
# Comparator tick timer with write confirmation

This block is a register-mapped timer built around a free-running 64-bit count and a single 64-bit compare value. Software reaches both through 32-bit halves on a simple word-addressed register bus. Once a match has occurred, the compare value can step forward by a 32-bit increment on its own. This produces a steady stream of tick interrupts without any reprogramming.

Six registers do not take a write at once: the two count halves, the two compare halves, the increment and the control word. A write to one of them commits a fixed number of clock cycles after the bus cycle, `ACC_LAT` (default 2). In the cycle the new value lands, the hardware sets a status bit that belongs to that register. The bit stays set until software writes a 1 to it. A driver therefore writes a register, polls its bit, and clears the bit by writing a 1 to it.

Reads are combinational and return the live value. Software reads a consistent 64-bit count by reading the upper half, then the lower half, then the upper half again.

Top module: `cmp_tick_timer`

## Requirements

The following word addresses are used throughout:

| Address | Register |
|---|---|
| 0 | count low |
| 1 | count high |
| 2 | compare low |
| 3 | compare high |
| 4 | increment |
| 5 | control |
| 6 | interrupt enable |
| 7 | interrupt flag |
| 8 | count write status |
| 9 | general write status |

- R1: After reset, every register reads 0 and irq_o is low.
- R2: A write to address 0, 1, 2, 3, 4 or 5 commits in the clock edge `ACC_LAT` edges after the edge that sampled it. Until then, a read returns the old value. A read of any address returns the live register value in the same cycle.
- R3: When a count-low write commits, bit 0 of the count write status sets. When a count-high write commits, bit 1 sets. Each write replaces only its own 32-bit half.
- R4: Commits set bits of the general write status as follows: compare low sets bit 0, compare high sets bit 1, increment sets bit 2, and control sets bit 3. Each bit sets in the same edge as its register takes the new value.
- R5: Write status bits are sticky. Writing a 1 at a bit position of address 8 or 9 clears only that bit, at the sampling edge. Writing 0 has no effect.
- R6: Writes to addresses 6, 7, 8 and 9 take effect at the sampling edge and set no write status bit.
- R7: The control register has three bits: bit 0 is run, bit 1 is compare enable, and bit 2 is auto-step. The count increments by 1 on each edge only while run is 1. The increment carries from the low half into the high half and wraps modulo 2^64. While run is 0, the count holds its value.
- R8: A match is the condition run = 1, compare enable = 1 and count = compare value. A match sets the interrupt flag (address 7, bit 0) at the next edge. With auto-step at 0, the compare value is unchanged by the match.
- R9: With auto-step at 1, each match adds the increment (zero-extended) to the compare value at the next edge, modulo 2^64.
- R10: Writing 1 to bit 0 of address 7 clears the interrupt flag, and writing 0 leaves it unchanged. The output irq_o equals the flag ANDed with bit 0 of address 6.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Live read data for addr_i |
| irq_o | output | 1 | Gated tick interrupt |

## Verification

The bench builds the block with the default `ACC_LAT` of 2. This places the old-value window before a commit, the commit edge itself and the counting that follows all within a few cycles of each write, so each can be sampled cycle by cycle. The count can be preloaded to any value. With small compare and increment values, repeated auto-step matches occur within tens of cycles. Preloading the count and compare value near 2^64 exercises the 64-bit wrap of both the count and the auto-step addition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 2 * DW;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    A_CNT_LO = 4'd0,
    A_CNT_HI = 4'd1,
    A_CMP_LO = 4'd2,
    A_CMP_HI = 4'd3,
    A_INCR   = 4'd4,
    A_CTRL   = 4'd5,
    A_IRQ_EN = 4'd6,
    A_IRQ_ST = 4'd7,
    A_CNT_WS = 4'd8,
    A_GEN_WS = 4'd9
  } reg_addr_e;

  localparam int unsigned CTRL_RUN    = 0;
  localparam int unsigned CTRL_CMP_EN = 1;
  localparam int unsigned CTRL_AUTO   = 2;
  localparam int unsigned CTRL_W      = 3;

  localparam int unsigned CNT_WS_W = 2;
  localparam int unsigned GEN_WS_W = 4;

  typedef struct packed {
    logic          vld;
    logic [AW-1:0] idx;
    logic [DW-1:0] data;
  } wr_item_t;

  function automatic logic is_delayed(logic [AW-1:0] a);
    return (a <= 4'(A_CTRL));
  endfunction
endpackage

// File: rtl/tmr_wr_pipe.sv
module tmr_wr_pipe
  import tmr_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wr_item_t in_i,
  output wr_item_t out_o
);
  wr_item_t stg [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '0;
      else if (g == 0) stg[g] <= in_i;
      else stg[g] <= stg[(g == 0) ? 0 : g - 1];
    end
  end

  assign out_o = stg[LAT-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ld_lo_i) cnt_q[DW-1:0] <= ld_data_i;
    else if (ld_hi_i) cnt_q[CW-1:DW] <= ld_data_i;
    else if (run_i)   cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_comparator.sv
module tmr_comparator
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          armed_i,
  input  logic          auto_i,
  input  logic [DW-1:0] step_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [CW-1:0] cmp_o,
  output logic          match_o
);
  logic [CW-1:0] cmp_q;

  assign match_o = armed_i && (cnt_i == cmp_q);

  // a committed write wins over the auto-step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cmp_q <= '0;
    else if (ld_lo_i)             cmp_q[DW-1:0] <= ld_data_i;
    else if (ld_hi_i)             cmp_q[CW-1:DW] <= ld_data_i;
    else if (match_o && auto_i)   cmp_q <= cmp_q + {{(CW-DW){1'b0}}, step_i};
  end

  assign cmp_o = cmp_q;
endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ACC_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic                bus_wr;
  wr_item_t            pipe_in, commit;
  logic                commit_vld;
  logic [AW-1:0]       commit_idx;
  logic                c_cnt_lo, c_cnt_hi, c_cmp_lo, c_cmp_hi, c_incr, c_ctrl;
  logic [CW-1:0]       cnt, cmp;
  logic                match;
  logic [DW-1:0]       incr_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                irq_en_q, irq_st_q;
  logic [CNT_WS_W-1:0] cnt_ws_q, cnt_ws_set, cnt_ws_clr;
  logic [GEN_WS_W-1:0] gen_ws_q, gen_ws_set, gen_ws_clr;

  assign bus_wr = req_i && we_i;

  assign pipe_in.vld  = bus_wr && is_delayed(addr_i);
  assign pipe_in.idx  = addr_i;
  assign pipe_in.data = wdata_i;

  tmr_wr_pipe #(.LAT(ACC_LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (pipe_in),
    .out_o (commit)
  );

  assign commit_vld = commit.vld;
  assign commit_idx = commit.idx;
  assign c_cnt_lo = commit_vld && (commit_idx == A_CNT_LO);
  assign c_cnt_hi = commit_vld && (commit_idx == A_CNT_HI);
  assign c_cmp_lo = commit_vld && (commit_idx == A_CMP_LO);
  assign c_cmp_hi = commit_vld && (commit_idx == A_CMP_HI);
  assign c_incr   = commit_vld && (commit_idx == A_INCR);
  assign c_ctrl   = commit_vld && (commit_idx == A_CTRL);

  tmr_counter u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q[CTRL_RUN]),
    .ld_lo_i  (c_cnt_lo),
    .ld_hi_i  (c_cnt_hi),
    .ld_data_i(commit.data),
    .cnt_o    (cnt)
  );

  tmr_comparator u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (ctrl_q[CTRL_RUN] && ctrl_q[CTRL_CMP_EN]),
    .auto_i   (ctrl_q[CTRL_AUTO]),
    .step_i   (incr_q),
    .cnt_i    (cnt),
    .ld_lo_i  (c_cmp_lo),
    .ld_hi_i  (c_cmp_hi),
    .ld_data_i(commit.data),
    .cmp_o    (cmp),
    .match_o  (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      incr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (c_incr) incr_q <= commit.data;
      if (c_ctrl) ctrl_q <= commit.data[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      irq_st_q <= 1'b0;
    end else begin
      if (bus_wr && addr_i == A_IRQ_EN) irq_en_q <= wdata_i[0];
      if (match) irq_st_q <= 1'b1;
      else if (bus_wr && addr_i == A_IRQ_ST && wdata_i[0]) irq_st_q <= 1'b0;
    end
  end

  // write status: set on commit, cleared by write-1, set wins
  assign cnt_ws_set = {c_cnt_hi, c_cnt_lo};
  assign gen_ws_set = {c_ctrl, c_incr, c_cmp_hi, c_cmp_lo};
  assign cnt_ws_clr = (bus_wr && addr_i == A_CNT_WS) ? wdata_i[CNT_WS_W-1:0] : '0;
  assign gen_ws_clr = (bus_wr && addr_i == A_GEN_WS) ? wdata_i[GEN_WS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_ws_q <= '0;
      gen_ws_q <= '0;
    end else begin
      cnt_ws_q <= (cnt_ws_q & ~cnt_ws_clr) | cnt_ws_set;
      gen_ws_q <= (gen_ws_q & ~gen_ws_clr) | gen_ws_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CNT_LO: rdata_o = cnt[DW-1:0];
      A_CNT_HI: rdata_o = cnt[CW-1:DW];
      A_CMP_LO: rdata_o = cmp[DW-1:0];
      A_CMP_HI: rdata_o = cmp[CW-1:DW];
      A_INCR:   rdata_o = incr_q;
      A_CTRL:   rdata_o = DW'(ctrl_q);
      A_IRQ_EN: rdata_o = DW'(irq_en_q);
      A_IRQ_ST: rdata_o = DW'(irq_st_q);
      A_CNT_WS: rdata_o = DW'(cnt_ws_q);
      A_GEN_WS: rdata_o = DW'(gen_ws_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_st_q && irq_en_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_wr_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       wdata_i,
  input logic                commit_vld_i,
  input logic [AW-1:0]       commit_idx_i,
  input logic [CW-1:0]       cnt_i,
  input logic [CW-1:0]       cmp_i,
  input logic [DW-1:0]       incr_i,
  input logic [CTRL_W-1:0]   ctrl_i,
  input logic                match_i,
  input logic                irq_st_i,
  input logic                irq_en_i,
  input logic                irq_i,
  input logic [CNT_WS_W-1:0] cnt_ws_i,
  input logic [GEN_WS_W-1:0] gen_ws_i
);
  logic cnt_ld, cmp_ld;
  assign cnt_ld = commit_vld_i && (commit_idx_i == A_CNT_LO || commit_idx_i == A_CNT_HI);
  assign cmp_ld = commit_vld_i && (commit_idx_i == A_CMP_LO || commit_idx_i == A_CMP_HI);

  a_r7_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[CTRL_RUN] && !cnt_ld) |=> cnt_i == $past(cnt_i));

  a_r7_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[CTRL_RUN] && !cnt_ld) |=> cnt_i == $past(cnt_i) + CW'(1));

  a_r8_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> irq_st_i);

  a_r8_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !ctrl_i[CTRL_AUTO] && !cmp_ld) |=> cmp_i == $past(cmp_i));

  a_r9_auto_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && ctrl_i[CTRL_AUTO] && !cmp_ld) |=>
      cmp_i == $past(cmp_i) + {{(CW-DW){1'b0}}, $past(incr_i)});

  a_r3_lo_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_vld_i && commit_idx_i == A_CNT_LO) |=> cnt_ws_i[0]);

  a_r4_ctrl_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_vld_i && commit_idx_i == A_CTRL) |=> gen_ws_i[3]);

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ws_i[0] && !(bus_wr_i && addr_i == A_CNT_WS && wdata_i[0])) |=> cnt_ws_i[0]);

  a_r6_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && addr_i == A_IRQ_EN && !commit_vld_i) |=>
      (cnt_ws_i == $past(cnt_ws_i) && gen_ws_i == $past(gen_ws_i)));

  a_r10_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i);
endmodule

bind cmp_tick_timer tmr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .commit_vld_i(commit_vld),
  .commit_idx_i(commit_idx),
  .cnt_i       (cnt),
  .cmp_i       (cmp),
  .incr_i      (incr_q),
  .ctrl_i      (ctrl_q),
  .match_i     (match),
  .irq_st_i    (irq_st_q),
  .irq_en_i    (irq_en_q),
  .irq_i       (irq_o),
  .cnt_ws_i    (cnt_ws_q),
  .gen_ws_i    (gen_ws_q)
);

// File: tb/sim_cmp_tick_timer.sv
`timescale 1ns/100ps
module sim_cmp_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  cmp_tick_timer u0 (.*);

  always #2 clk_i = ~clk_i;

  localparam logic [3:0] CLO = 0, CHI = 1, KLO = 2, KHI = 3, INC = 4, CTL = 5,
                         IEN = 6, IST = 7, CWS = 8, GWS = 9;

  typedef struct {
    bit          is_irq;
    logic [3:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : rdata_o;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr_i = a;
    #0.1;
    it.is_irq = 0; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #0.1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    #0.1;
    it.is_irq = 1; it.a = 0; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #0.1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    chk(CLO, 0, "R1 cnt_lo"); chk(CHI, 0, "R1 cnt_hi"); chk(KLO, 0, "R1 cmp_lo");
    chk(CTL, 0, "R1 ctrl");   chk(CWS, 0, "R1 cnt_ws"); chk(GWS, 0, "R1 gen_ws");
    chk_irq(0, "R1 irq");

    // R2 latency, R3 count status
    wr(CLO, 32'h10);
    chk(CLO, 0, "R2 old value"); chk(CWS, 0, "R2 no status yet");
    tick(1);
    chk(CLO, 0, "R2 still old");
    tick(1);
    chk(CLO, 32'h10, "R2 committed"); chk(CWS, 1, "R3 lo status");
    wr(CHI, 5); tick(2);
    chk(CHI, 5, "R3 hi value"); chk(CLO, 32'h10, "R3 lo kept"); chk(CWS, 3, "R3 hi status");

    // R5 write-1-to-clear
    wr(CWS, 1); chk(CWS, 2, "R5 clear bit0 only");
    wr(CWS, 0); chk(CWS, 2, "R5 write 0 no effect");
    wr(CWS, 2); chk(CWS, 0, "R5 clear bit1");

    // R6 immediate registers set no status
    wr(IEN, 1); tick(3);
    chk(CWS, 0, "R6 cnt_ws"); chk(GWS, 0, "R6 gen_ws"); chk(IEN, 1, "R6 irq_en value");
    wr(IST, 1); tick(3);
    chk(GWS, 0, "R6 gen_ws after irq_st");

    // R4 general status bits
    wr(KLO, 10); tick(2); chk(GWS, 1, "R4 cmp_lo bit"); chk(KLO, 10, "R4 cmp_lo value");
    wr(KHI, 0);  tick(2); chk(GWS, 3, "R4 cmp_hi bit");
    wr(INC, 5);  tick(2); chk(GWS, 7, "R4 incr bit"); chk(INC, 5, "R4 incr value");
    wr(GWS, 7);  chk(GWS, 0, "R5 gen clear");

    // R7/R8/R9/R10 periodic auto-step
    wr(CLO, 0); wr(CHI, 0); tick(2);
    wr(CTL, 7);
    tick(2);
    chk(GWS, 8, "R4 ctrl bit"); chk(CLO, 0, "R7 no count at commit");
    tick(1);  chk(CLO, 1, "R7 counting");
    tick(9);
    chk(CLO, 10, "R7 count"); chk_irq(0, "R8 before match"); chk(KLO, 10, "R9 cmp before");
    tick(1);
    chk(CLO, 11, "R7 count"); chk_irq(1, "R8 match irq"); chk(IST, 1, "R8 flag");
    chk(KLO, 15, "R9 auto step"); chk(KHI, 0, "R9 cmp_hi");
    wr(IST, 1);
    chk(CLO, 12, "R7 count"); chk_irq(0, "R10 cleared");
    tick(3); chk_irq(0, "R9 before second match");
    tick(1); chk(CLO, 16, "R7 count"); chk_irq(1, "R9 second match"); chk(KLO, 20, "R9 step 2");
    wr(IEN, 0); chk_irq(0, "R10 gated off"); chk(IST, 1, "R10 flag kept");
    wr(IEN, 1); chk_irq(1, "R10 gated on");
    wr(IST, 0); chk_irq(1, "R10 write 0 no effect");
    wr(IST, 1); chk(CLO, 20, "R7 count");

    // R7 stop holds count
    wr(CTL, 0); tick(2);
    chk(CLO, 23, "R7 stops after commit");
    tick(5); chk(CLO, 23, "R7 held");
    wr(IST, 1); chk(IST, 0, "R10 flag cleared");

    // R8 no auto-step keeps compare value
    wr(CLO, 0); wr(KLO, 4); tick(2);
    wr(CTL, 3);
    tick(6); chk(CLO, 4, "R8 count"); chk_irq(0, "R8 pre match");
    tick(1); chk_irq(1, "R8 match"); chk(KLO, 4, "R8 cmp unchanged");
    wr(IST, 1); tick(5);
    chk_irq(0, "R8 no rematch"); chk(KLO, 4, "R8 cmp still");

    // R9 64-bit wrap of compare, R7 64-bit wrap of count, R2 live read
    wr(CTL, 0); tick(2);
    wr(CLO, 32'hFFFF_FFFC); wr(CHI, 32'hFFFF_FFFF);
    wr(KLO, 32'hFFFF_FFFE); wr(KHI, 32'hFFFF_FFFF); tick(2);
    wr(IST, 1);
    wr(CTL, 7);
    tick(4); chk(CLO, 32'hFFFF_FFFE, "R7 pre wrap"); chk_irq(0, "R9 pre wrap");
    tick(1);
    chk(CHI, 32'hFFFF_FFFF, "R2 live hi"); chk(CLO, 32'hFFFF_FFFF, "R2 live lo");
    chk_irq(1, "R9 wrap match"); chk(KLO, 3, "R9 cmp wrap lo"); chk(KHI, 0, "R9 cmp wrap hi");
    tick(1);
    chk(CHI, 0, "R7 carry wrap hi"); chk(CLO, 0, "R7 carry wrap lo");

    tick(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule